// File: doc/BRIEF.md
# Type-0 PCI configuration header register file

This block is the configuration-space target of a PCI function. It answers 32-bit configuration reads and writes, addressed by dword index and qualified by byte enables. It holds the fixed identification words, a command register with a write mask, a read-only status word, and six base address register slots. A read returns registered data one cycle after the request.

A build-time parameter set defines the banks behind the base address slots. Each bank has a power-of-two size and a type nibble: I/O, 64-bit and prefetchable. Slot allocation starts after a configured number of skipped leading slots. Each bank then takes one slot, or two adjacent slots if it is 64-bit, with the low word first.

The block exports every bank's current base, size and type. It also raises a single-cycle remap pulse after any write to a linked base slot, so that the address decoders around it can reprogram their windows.

Top module: `pci_cfg_header`

## Requirements
- R1: After reset the command register reads 0x0080, every bank base and every high base word is zero, and `remap_o` and `cfg_rvalid` are low.
- R2: A read request returns data on `cfg_rdata`, with `cfg_rvalid` high, in the cycle after the request edge. Dword 0 returns {device id, vendor id}. Dword 2 returns the class/revision word. Dword 3 returns {BIST, header type, latency timer, cache line size}, highest byte first. Dword 11 returns {subsystem id, subsystem vendor id}. Dword 13 returns the capability pointer in bits 7:0 and zero above.
- R3: Dword 1 reads {status, command}. A write changes only the command bits that are set in 0x01BF and that lie in an enabled byte. Bits 31:16 (status) are read-only.
- R4: A base slot (dwords 4..9) that is linked to no bank reads zero, ignores writes and raises no remap pulse.
- R5: Slot allocation begins at slot `SKIP_SLOTS`. Banks take slots in bank order. A 64-bit bank takes two consecutive slots, low word first. A write to one bank's slot leaves every other bank unchanged.
- R6: A low-word slot reads the bank base low word ORed with type bits: bit 0 for I/O, bit 2 for 64-bit, bit 3 for prefetchable.
- R7: A low-word write merges the enabled bytes into the current low word and clears the bits below the bank size. It leaves the upper 32 bits of the base unchanged.
- R8: A high-word write replaces only the upper 32 bits of its bank's base, honouring the byte enables.
- R9: `remap_o` is high for exactly the one cycle after the edge that accepts a write to a linked base slot. It is high at no other time.
- R10: `bank_base_o`, `bank_size_o` and `bank_flags_o` carry each bank's 64-bit base, its size and its type nibble, with bank b in the b-th field from the LSB.
- R11: Reads of dwords outside those listed return zero. Writes to them, and to dwords 0, 2, 3, 11 and 13, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Access request, one cycle per access |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_idx | input | 6 | Dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bank_base_o | output | NUM_BANKS*64 | Current base of each bank |
| bank_size_o | output | NUM_BANKS*32 | Size of each bank |
| bank_flags_o | output | NUM_BANKS*4 | Type nibble of each bank |
| remap_o | output | 1 | One-cycle pulse after a linked base write |

## Verification
Read data and `cfg_rvalid` are due one cycle after the edge that accepts the request. Register state and the exported bank fields change at that same edge. `remap_o` is high from that edge until the next one. The bench drives each request on a falling edge and withdraws it on the next falling edge. At that point it samples read data, `cfg_rvalid` and `remap_o`, and it samples `remap_o` once more a full cycle later to confirm the pulse has ended. The base-slot expectations are derived from the default slot layout: slot 0 skipped, a 64-bit prefetchable bank in slots 1-2, an I/O bank in slot 3, a 32-bit memory bank in slot 4, and slot 5 free.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

  localparam int NUM_SLOTS     = 6;
  localparam int SLOT_BASE_IDX = 4;

  localparam logic [15:0] CMD_RESET = 16'h0080;
  localparam logic [15:0] CMD_WMASK = 16'h01BF;

  // type nibble bit positions, also their positions in a low-word read
  localparam int TYPE_IO   = 0;
  localparam int TYPE_W64  = 2;
  localparam int TYPE_PREF = 3;

  typedef struct packed {
    logic       linked;
    logic       hi;
    logic [2:0] bank;
  } slot_link_t;

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [31:0] merge_bytes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  be);
    logic [31:0] m;
    m = be_mask(be);
    return (old_w & ~m) | (new_w & m);
  endfunction

  function automatic logic [31:0] align_keep(input logic [31:0] size);
    return ~(size - 32'd1);
  endfunction

  function automatic logic [31:0] type_bits(input logic [3:0] flags);
    logic [31:0] t;
    t = '0;
    t[0] = flags[TYPE_IO];
    t[2] = flags[TYPE_W64];
    t[3] = flags[TYPE_PREF];
    return t;
  endfunction

endpackage

// File: rtl/pci_cfg_cmd_reg.sv
module pci_cfg_cmd_reg
  import pci_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [15:0] wdata,
  input  logic [1:0]  be,
  output logic [15:0] cmd_o
);

  logic [15:0] wr_bits;

  always_comb begin
    wr_bits = CMD_WMASK & {{8{be[1]}}, {8{be[0]}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cmd_o <= CMD_RESET;
    else if (wr) cmd_o <= (cmd_o & ~wr_bits) | (wdata & wr_bits);
  end

  // R3: bits outside the write mask keep their reset value
  assert_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o & ~CMD_WMASK) == (CMD_RESET & ~CMD_WMASK));

  assert_cmd_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cmd_o));

endmodule

// File: rtl/pci_cfg_bar_bank.sv
module pci_cfg_bar_bank
  import pci_cfg_pkg::*;
#(
  parameter logic [31:0] SIZE  = 32'h100,
  parameter logic [3:0]  FLAGS = 4'h0
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  output logic [63:0] base_o,
  output logic [31:0] rd_lo,
  output logic [31:0] rd_hi
);

  localparam logic [31:0] KEEP = align_keep(SIZE);
  localparam logic [31:0] TBITS = type_bits(FLAGS);

  logic [31:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= merge_bytes(lo_q, wdata, be) & KEEP;
      if (wr_hi && FLAGS[TYPE_W64]) hi_q <= merge_bytes(hi_q, wdata, be);
    end
  end

  assign base_o = {hi_q, lo_q};
  assign rd_lo  = lo_q | TBITS;
  assign rd_hi  = hi_q;

  // R7: a low write leaves the base aligned to the bank size
  assert_low_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (base_o[31:0] & ~KEEP) == 32'h0);

  assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> base_o[63:32] == $past(base_o[63:32]));

  assert_lower_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> base_o[31:0] == $past(base_o[31:0]));

  assert_bank_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> $stable(base_o));

endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID     = 16'h3C4D,
  parameter logic [31:0] CLASS_REV     = 32'h0C050002,
  parameter logic [7:0]  CACHE_LINE    = 8'h10,
  parameter logic [7:0]  LAT_TIMER     = 8'h20,
  parameter logic [7:0]  HDR_TYPE      = 8'h00,
  parameter logic [7:0]  BIST_VAL      = 8'h00,
  parameter logic [15:0] SUB_VENDOR    = 16'h5E6F,
  parameter logic [15:0] SUB_ID        = 16'h7081,
  parameter logic [7:0]  CAP_PTR       = 8'h40,
  parameter logic [15:0] STATUS_VAL    = 16'h0210,
  parameter int          NUM_BANKS     = 3,
  parameter int          SKIP_SLOTS    = 1,
  parameter logic [NUM_BANKS*32-1:0] BANK_SIZES = {32'h100, 32'h20, 32'h1000},
  parameter logic [NUM_BANKS*4-1:0]  BANK_FLAGS = {4'h0, 4'h1, 4'hC}
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_req,
  input  logic                    cfg_we,
  input  logic [5:0]              cfg_idx,
  input  logic [3:0]              cfg_be,
  input  logic [31:0]             cfg_wdata,
  output logic [31:0]             cfg_rdata,
  output logic                    cfg_rvalid,
  output logic [NUM_BANKS*64-1:0] bank_base_o,
  output logic [NUM_BANKS*32-1:0] bank_size_o,
  output logic [NUM_BANKS*4-1:0]  bank_flags_o,
  output logic                    remap_o
);

  localparam logic [5:0] IDX_ID     = 6'd0;
  localparam logic [5:0] IDX_CMD    = 6'd1;
  localparam logic [5:0] IDX_CLASS  = 6'd2;
  localparam logic [5:0] IDX_MISC   = 6'd3;
  localparam logic [5:0] IDX_SUBSYS = 6'd11;
  localparam logic [5:0] IDX_CAP    = 6'd13;

  // first slot taken by bank b
  function automatic int first_slot(input int b);
    int cur;
    cur = SKIP_SLOTS;
    for (int k = 0; k < b; k++) cur += BANK_FLAGS[k*4 + TYPE_W64] ? 2 : 1;
    return cur;
  endfunction

  // owner of base slot s
  function automatic slot_link_t link_of(input int s);
    slot_link_t r;
    int cur;
    r   = '0;
    cur = SKIP_SLOTS;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (s == cur) begin
        r.linked = 1'b1; r.hi = 1'b0; r.bank = 3'(b);
      end
      if (BANK_FLAGS[b*4 + TYPE_W64] && s == cur + 1) begin
        r.linked = 1'b1; r.hi = 1'b1; r.bank = 3'(b);
      end
      cur += BANK_FLAGS[b*4 + TYPE_W64] ? 2 : 1;
    end
    return r;
  endfunction

  // named internal events
  logic                 rd_acc;
  logic                 wr_acc;
  logic                 cmd_wr;
  logic [NUM_BANKS-1:0] wr_lo;
  logic [NUM_BANKS-1:0] wr_hi;
  logic                 bar_write_hit;

  logic [15:0] cmd_q;
  logic [31:0] rd_lo [NUM_BANKS];
  logic [31:0] rd_hi [NUM_BANKS];
  logic [31:0] slot_rd [NUM_SLOTS];
  logic [31:0] rd_mux;

  assign rd_acc = cfg_req && !cfg_we;
  assign wr_acc = cfg_req && cfg_we;
  assign cmd_wr = wr_acc && (cfg_idx == IDX_CMD);

  pci_cfg_cmd_reg u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cmd_wr),
    .wdata (cfg_wdata[15:0]),
    .be    (cfg_be[1:0]),
    .cmd_o (cmd_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int          LO_SLOT = first_slot(b);
    localparam logic [3:0]  FLG     = BANK_FLAGS[b*4 +: 4];
    localparam logic [31:0] SZ      = BANK_SIZES[b*32 +: 32];

    assign wr_lo[b] = wr_acc && (int'(cfg_idx) == SLOT_BASE_IDX + LO_SLOT)
                      && (LO_SLOT < NUM_SLOTS);
    if (FLG[TYPE_W64]) begin : g_w64
      assign wr_hi[b] = wr_acc && (int'(cfg_idx) == SLOT_BASE_IDX + LO_SLOT + 1)
                        && (LO_SLOT + 1 < NUM_SLOTS);
    end else begin : g_w32
      assign wr_hi[b] = 1'b0;
    end

    pci_cfg_bar_bank #(.SIZE(SZ), .FLAGS(FLG)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (wr_lo[b]),
      .wr_hi  (wr_hi[b]),
      .wdata  (cfg_wdata),
      .be     (cfg_be),
      .base_o (bank_base_o[b*64 +: 64]),
      .rd_lo  (rd_lo[b]),
      .rd_hi  (rd_hi[b])
    );

    assign bank_size_o[b*32 +: 32] = SZ;
    assign bank_flags_o[b*4 +: 4]  = FLG;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam slot_link_t LNK = link_of(s);
    if (LNK.linked && LNK.hi) begin : g_hi
      assign slot_rd[s] = rd_hi[LNK.bank];
    end else if (LNK.linked) begin : g_lo
      assign slot_rd[s] = rd_lo[LNK.bank];
    end else begin : g_free
      assign slot_rd[s] = '0;
    end
  end

  assign bar_write_hit = (|wr_lo) || (|wr_hi);

  always_comb begin
    rd_mux = '0;
    case (cfg_idx)
      IDX_ID:     rd_mux = {DEVICE_ID, VENDOR_ID};
      IDX_CMD:    rd_mux = {STATUS_VAL, cmd_q};
      IDX_CLASS:  rd_mux = CLASS_REV;
      IDX_MISC:   rd_mux = {BIST_VAL, HDR_TYPE, LAT_TIMER, CACHE_LINE};
      IDX_SUBSYS: rd_mux = {SUB_ID, SUB_VENDOR};
      IDX_CAP:    rd_mux = {24'h0, CAP_PTR};
      6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9:
                  rd_mux = slot_rd[int'(cfg_idx) - SLOT_BASE_IDX];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
      remap_o    <= 1'b0;
    end else begin
      cfg_rvalid <= rd_acc;
      remap_o    <= bar_write_hit;
      if (rd_acc) cfg_rdata <= rd_mux;
    end
  end

  // R9: the remap pulse follows every linked base write and nothing else
  assert_remap_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bar_write_hit |=> remap_o);

  assert_remap_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    remap_o |-> $past(bar_write_hit));

  // R2: read data valid one cycle after the request
  assert_rvalid_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> cfg_rvalid);

  assert_rvalid_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid |-> $past(rd_acc));

  // R5: one access reaches at most one base slot
  assert_single_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_lo, wr_hi}));

endmodule

// File: tb/pci_cfg_header_tb.sv
`timescale 1ns/1ps
module pci_cfg_header_tb;

  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_req = 1'b0, cfg_we = 1'b0;
  logic [5:0]    cfg_idx = '0;
  logic [3:0]    cfg_be = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          cfg_rvalid;
  logic [NB*64-1:0] bank_base_o;
  logic [NB*32-1:0] bank_size_o;
  logic [NB*4-1:0]  bank_flags_o;
  logic          remap_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] seen_rdata;
  logic        seen_rvalid, seen_remap, seen_remap_next;

  always #4 clk = ~clk;

  pci_cfg_header u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .bank_base_o(bank_base_o), .bank_size_o(bank_size_o),
    .bank_flags_o(bank_flags_o), .remap_o(remap_o)
  );

  typedef struct packed {
    logic        we;
    logic [5:0]  idx;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  4'hF, 32'h0, 32'h3C4D1A2B, 4'd2},  // R2 ids
    '{1'b0, 6'd1,  4'hF, 32'h0, 32'h02100080, 4'd1},  // R1 command reset
    '{1'b0, 6'd2,  4'hF, 32'h0, 32'h0C050002, 4'd2},  // R2 class
    '{1'b0, 6'd3,  4'hF, 32'h0, 32'h00002010, 4'd2},  // R2 misc bytes
    '{1'b0, 6'd11, 4'hF, 32'h0, 32'h70815E6F, 4'd2},  // R2 subsystem
    '{1'b0, 6'd13, 4'hF, 32'h0, 32'h00000040, 4'd2},  // R2 cap pointer
    '{1'b0, 6'd14, 4'hF, 32'h0, 32'h00000000, 4'd11}, // R11 unmapped
    '{1'b0, 6'd4,  4'hF, 32'h0, 32'h00000000, 4'd4},  // R4 skipped slot
    '{1'b0, 6'd5,  4'hF, 32'h0, 32'h0000000C, 4'd6},  // R6 64b pref
    '{1'b0, 6'd7,  4'hF, 32'h0, 32'h00000001, 4'd6},  // R6 io
    '{1'b0, 6'd8,  4'hF, 32'h0, 32'h00000000, 4'd6},  // R6 plain mem
    '{1'b0, 6'd6,  4'hF, 32'h0, 32'h00000000, 4'd1},  // R1 high word zero
    '{1'b1, 6'd1,  4'hF, 32'hFFFFFFFF, 32'h0, 4'd3},
    '{1'b0, 6'd1,  4'hF, 32'h0, 32'h021001BF, 4'd3},  // R3 mask
    '{1'b1, 6'd1,  4'h1, 32'h0, 32'h0, 4'd3},
    '{1'b0, 6'd1,  4'hF, 32'h0, 32'h02100100, 4'd3},  // R3 byte enable
    '{1'b1, 6'd1,  4'hC, 32'h0, 32'h0, 4'd3},
    '{1'b0, 6'd1,  4'hF, 32'h0, 32'h02100100, 4'd3},  // R3 status read-only
    '{1'b1, 6'd5,  4'hF, 32'hFFFFFFFF, 32'h0, 4'd7},
    '{1'b0, 6'd5,  4'hF, 32'h0, 32'hFFFFF00C, 4'd7},  // R7 size mask
    '{1'b0, 6'd6,  4'hF, 32'h0, 32'h00000000, 4'd7},  // R7 upper kept
    '{1'b1, 6'd6,  4'hF, 32'h12345678, 32'h0, 4'd8},
    '{1'b0, 6'd6,  4'hF, 32'h0, 32'h12345678, 4'd8},  // R8 upper written
    '{1'b0, 6'd5,  4'hF, 32'h0, 32'hFFFFF00C, 4'd8},  // R8 lower kept
    '{1'b1, 6'd5,  4'h2, 32'h0000AB00, 32'h0, 4'd7},
    '{1'b0, 6'd5,  4'hF, 32'h0, 32'hFFFFA00C, 4'd7},  // R7 byte merge
    '{1'b0, 6'd6,  4'hF, 32'h0, 32'h12345678, 4'd7},  // R7 upper kept
    '{1'b1, 6'd7,  4'hF, 32'hFFFFFFFF, 32'h0, 4'd7},
    '{1'b0, 6'd7,  4'hF, 32'h0, 32'hFFFFFFE1, 4'd6},  // R6 io after write
    '{1'b1, 6'd4,  4'hF, 32'hFFFFFFFF, 32'h0, 4'd4},
    '{1'b0, 6'd4,  4'hF, 32'h0, 32'h00000000, 4'd4},  // R4 slot 0
    '{1'b1, 6'd9,  4'hF, 32'hFFFFFFFF, 32'h0, 4'd4},
    '{1'b0, 6'd9,  4'hF, 32'h0, 32'h00000000, 4'd4},  // R4 slot 5
    '{1'b1, 6'd2,  4'hF, 32'hFFFFFFFF, 32'h0, 4'd11},
    '{1'b0, 6'd2,  4'hF, 32'h0, 32'h0C050002, 4'd11}, // R11 read-only
    '{1'b1, 6'd8,  4'hF, 32'h12345678, 32'h0, 4'd5},
    '{1'b0, 6'd8,  4'hF, 32'h0, 32'h12345600, 4'd5},  // R5 slot 4 bank
    '{1'b0, 6'd5,  4'hF, 32'h0, 32'hFFFFA00C, 4'd5}   // R5 other bank kept
  };

  task automatic check(input string req, input logic [63:0] got,
                       input logic [63:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic cfg_op(input logic we, input logic [5:0] idx,
                        input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = we; cfg_idx = idx; cfg_be = be; cfg_wdata = wd;
    @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0;
    seen_rdata  = cfg_rdata;
    seen_rvalid = cfg_rvalid;
    seen_remap  = remap_o;
    @(negedge clk);
    seen_remap_next = remap_o;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {63'h0, remap_o}, 64'h0, "remap in reset");
    check("R1", {63'h0, cfg_rvalid}, 64'h0, "rvalid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", bank_base_o[63:0], 64'h0, "bank0 base");
    check("R1", bank_base_o[127:64], 64'h0, "bank1 base");
    check("R1", bank_base_o[191:128], 64'h0, "bank2 base");

    // R2: read timing and valid flag
    cfg_op(1'b0, 6'd0, 4'hF, 32'h0);
    check("R2", {63'h0, seen_rvalid}, 64'h1, "rvalid after read");

    for (int i = 0; i < NV; i++) begin
      cfg_op(VECS[i].we, VECS[i].idx, VECS[i].be, VECS[i].wd);
      if (!VECS[i].we) begin
        checks++;
        if (seen_rdata !== VECS[i].exp) begin
          errors++;
          $display("FAIL R%0d vector %0d: got %h expected %h",
                   VECS[i].req, i, seen_rdata, VECS[i].exp);
        end
      end
    end

    // R10: exported bank state
    check("R10", bank_base_o[63:0], 64'h12345678_FFFFA000, "bank0 base");
    check("R10", bank_base_o[127:64], 64'h00000000_FFFFFFE0, "bank1 base");
    check("R10", bank_base_o[191:128], 64'h00000000_12345600, "bank2 base");
    check("R10", {32'h0, bank_size_o[31:0]}, 64'h1000, "bank0 size");
    check("R10", {32'h0, bank_size_o[63:32]}, 64'h20, "bank1 size");
    check("R10", {32'h0, bank_size_o[95:64]}, 64'h100, "bank2 size");
    check("R10", {52'h0, bank_flags_o}, 64'h01C, "flags");

    // R9: remap pulse timing
    cfg_op(1'b1, 6'd7, 4'hF, 32'h00000040);
    check("R9", {63'h0, seen_remap}, 64'h1, "remap after bar write");
    check("R9", {63'h0, seen_remap_next}, 64'h0, "remap one cycle only");
    cfg_op(1'b1, 6'd6, 4'h1, 32'h000000AA);
    check("R9", {63'h0, seen_remap}, 64'h1, "remap after high write");
    check("R8", bank_base_o[63:0], 64'h123456AA_FFFFA000, "high byte merge");
    cfg_op(1'b1, 6'd4, 4'hF, 32'hFFFFFFFF);
    check("R4", {63'h0, seen_remap}, 64'h0, "no remap on free slot");
    cfg_op(1'b1, 6'd1, 4'hF, 32'h0);
    check("R9", {63'h0, seen_remap}, 64'h0, "no remap on command");
    cfg_op(1'b1, 6'd20, 4'hF, 32'hFFFFFFFF);
    check("R11", {63'h0, seen_remap}, 64'h0, "no remap on unmapped");
    check("R5", bank_base_o[127:64], 64'h00000000_00000040, "io bank");
    cfg_op(1'b0, 6'd20, 4'hF, 32'h0);
    check("R11", {32'h0, seen_rdata}, 64'h0, "unmapped read");
    cfg_op(1'b0, 6'd1, 4'hF, 32'h0);
    check("R3", {32'h0, seen_rdata}, 64'h02100000, "command cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule